// File: doc/BRIEF.md
# Flash Toggle Status Bit Generator

This block produces the status word that a flash device returns while an embedded program or erase runs. Commands come in as decoded single-cycle pulses. A separate timing model signals the end of each operation with a done pulse. On every read strobe the block returns one registered 8-bit word. That word is either the array data on `arr_data` or a status word. In the status word, bit 6 inverts on reads while an operation is actively running. Bit 2 inverts on reads that fall in a sector chosen for erase. Every other bit reads 0.

A controller state machine holds the mode. Its states are ST_READ (array reads), ST_ERASE (active erase), ST_SUSP (erase suspended), ST_SUSP_PROG (program issued while erase is suspended), ST_PROG (program) and ST_PROT (timed toggling after a command aimed only at protected sectors). The transitions are:
- start-erase: ST_READ to ST_ERASE.
- erase-protected: ST_READ to ST_PROT.
- start-program: ST_READ to ST_PROG.
- program-protected: ST_READ or ST_SUSP to ST_PROT.
- suspend: ST_ERASE to ST_SUSP.
- resume: ST_SUSP to ST_ERASE.
- suspend-program: ST_SUSP to ST_SUSP_PROG.
- erase-done: ST_ERASE to ST_READ.
- program-done: ST_PROG to ST_READ.
- suspend-program-done: ST_SUSP_PROG to ST_SUSP.
- window-expired: ST_PROT back to the state it came from.

The two guard windows are cycle counts derived from the clock frequency parameter. The defaults are 100 us for erase and 1 us for program.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset `rd_valid` and `rd_data` are 0. `rd_valid` is high in exactly the cycle after each cycle with `rd_stb` high, and `rd_data` holds its value when there is no read.
- R2: In ST_READ a read returns the `arr_data` value sampled with the strobe.
- R3: During an active erase, every read at any sector returns a status word. Bit 6 starts at 0 for the first read after the operation starts and inverts on each following read. Bits 7, 5, 4, 3, 1 and 0 are 0.
- R4: During an active erase, bit 2 inverts only on reads whose `rd_sect` is an unprotected sector of `erase_sel`. Other reads leave it unchanged.
- R5: In ST_SUSP, a read of a selected sector returns a status word. In that word bit 6 keeps its last value and bit 2 inverts. A read of any other sector returns `arr_data`.
- R6: A `cmd_resume` pulse in ST_SUSP returns to ST_ERASE, where bit 6 toggles again.
- R7: A `cmd_prog` pulse to an unprotected sector in ST_SUSP clears both toggle bits and enters ST_SUSP_PROG. There bit 6 toggles on every read, and `op_done` returns to ST_SUSP.
- R8: A `cmd_erase` whose selected sectors are all set in `prot_map` enters ST_PROT for exactly CLK_HZ/1e6 x ERASE_GUARD_US cycles. During that time reads return status with bit 6 toggling. After that, reads return `arr_data`.
- R9: A `cmd_prog` to a sector set in `prot_map` enters ST_PROT for exactly CLK_HZ/1e6 x PROG_GUARD_US cycles, then returns to the state it came from.
- R10: When only some selected sectors are protected, the erase still starts. Bit 2 toggles only for the unprotected selected sectors.
- R11: A `cmd_prog` to an unprotected sector in ST_READ enters ST_PROG. There bit 6 toggles, bit 2 stays 0, and `op_done` returns to ST_READ.
- R12: A command pulse that is not legal in the current state has no effect. Examples are `cmd_susp` in ST_READ, `cmd_erase` outside ST_READ, and `cmd_resume` outside ST_SUSP.
- R13: The first read in the cycle right after the final command pulse already returns a status word with both toggle bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Read strobe, one per read |
| rd_sect | input | SECT_W | Sector index of the read address |
| arr_data | input | 8 | Array data word returned outside status mode |
| cmd_erase | input | 1 | Decoded erase command pulse |
| erase_sel | input | N_SECT | Sectors chosen for erase, sampled with `cmd_erase` |
| cmd_prog | input | 1 | Decoded program command pulse |
| prog_sect | input | SECT_W | Target sector of the program |
| prot_map | input | N_SECT | Per-sector protection flags |
| cmd_susp | input | 1 | Erase suspend pulse |
| cmd_resume | input | 1 | Erase resume pulse |
| op_done | input | 1 | Embedded operation finished |
| rd_data | output | 8 | Returned read word |
| rd_valid | output | 1 | `rd_data` updated by the previous cycle's read |

## Verification
The bench targets these corner cases:
- The last guard-window cycle followed by the first cycle after it. An off-by-one timer returns array data one read early, or status one read late.
- Reads of unselected sectors while suspended. A design that ignores the selection mask returns status there instead of array data.
- Reads that alternate between selected and unselected sectors during erase, including sectors that are selected but protected. Bit 2 drifts if the protection or selection mask is misapplied.
- The first read straight after a command, illegal commands in each state, and bit 6 held across suspend and resume. A design that fails to clear or hold its toggles shows a wrong starting phase.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int unsigned STAT_W  = 8;
    localparam int unsigned BIT_T6  = 6;
    localparam int unsigned BIT_T2  = 2;

    typedef enum logic [2:0] {
        ST_READ,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PROG,
        ST_PROG,
        ST_PROT
    } fts_state_e;

    function automatic logic [STAT_W-1:0] pack_status(input logic t6, input logic t2);
        logic [STAT_W-1:0] w;
        w         = '0;
        w[BIT_T6] = t6;
        w[BIT_T2] = t2;
        return w;
    endfunction

endpackage

// File: rtl/fts_timer.sv
module fts_timer #(
    parameter int unsigned LONG_WIN  = 5000,
    parameter int unsigned SHORT_WIN = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic zero
);
    localparam int unsigned CW = $clog2(LONG_WIN + 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_WIN - 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_WIN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= long_sel ? LONG_M1 : SHORT_M1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/fts_toggle.sv
module fts_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flip6,
    input  logic flip2,
    output logic t6,
    output logic t2
);
    logic t6_q;
    logic t2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
        end else if (clr) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
        end else begin
            if (flip6) t6_q <= ~t6_q;
            if (flip2) t2_q <= ~t2_q;
        end
    end

    assign t6 = t6_q;
    assign t2 = t2_q;

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int unsigned N_SECT = 8,
    parameter int unsigned SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic              cmd_erase,
    input  logic [N_SECT-1:0] erase_sel,
    input  logic              cmd_prog,
    input  logic [SECT_W-1:0] prog_sect,
    input  logic [N_SECT-1:0] prot_map,
    input  logic              cmd_susp,
    input  logic              cmd_resume,
    input  logic              op_done,
    input  logic              tim_zero,
    output fts_state_e        state,
    output logic              tim_load,
    output logic              tim_long,
    output logic              tog_clr,
    output logic              flip6,
    output logic              flip2,
    output logic              show_status
);
    fts_state_e        state_q, state_d;
    fts_state_e        ret_q, ret_d;
    logic [N_SECT-1:0] mask_q, mask_d;
    logic [N_SECT-1:0] eff_sel;
    logic              in_sel;

    assign eff_sel = erase_sel & ~prot_map;
    assign in_sel  = mask_q[rd_sect];

    always_comb begin
        state_d  = state_q;
        ret_d    = ret_q;
        mask_d   = mask_q;
        tim_load = 1'b0;
        tim_long = 1'b0;
        tog_clr  = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (cmd_erase && (erase_sel != '0)) begin
                    tog_clr = 1'b1;
                    if (eff_sel != '0) begin
                        state_d = ST_ERASE;
                        mask_d  = eff_sel;
                    end else begin
                        state_d  = ST_PROT;
                        ret_d    = ST_READ;
                        mask_d   = '0;
                        tim_load = 1'b1;
                        tim_long = 1'b1;
                    end
                end else if (cmd_prog) begin
                    tog_clr = 1'b1;
                    if (prot_map[prog_sect]) begin
                        state_d  = ST_PROT;
                        ret_d    = ST_READ;
                        tim_load = 1'b1;
                    end else begin
                        state_d = ST_PROG;
                    end
                end
            end
            ST_ERASE: begin
                if (cmd_susp) begin
                    state_d = ST_SUSP;
                end else if (op_done) begin
                    state_d = ST_READ;
                    mask_d  = '0;
                end
            end
            ST_SUSP: begin
                if (cmd_prog) begin
                    tog_clr = 1'b1;
                    if (prot_map[prog_sect]) begin
                        state_d  = ST_PROT;
                        ret_d    = ST_SUSP;
                        tim_load = 1'b1;
                    end else begin
                        state_d = ST_SUSP_PROG;
                    end
                end else if (cmd_resume) begin
                    state_d = ST_ERASE;
                end
            end
            ST_SUSP_PROG: begin
                if (op_done) state_d = ST_SUSP;
            end
            ST_PROG: begin
                if (op_done) state_d = ST_READ;
            end
            ST_PROT: begin
                if (tim_zero) state_d = ret_q;
            end
            default: state_d = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            ret_q   <= ST_READ;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        show_status = 1'b0;
        flip6       = 1'b0;
        flip2       = 1'b0;
        unique case (state_q)
            ST_READ: begin
                show_status = 1'b0;
            end
            ST_ERASE, ST_SUSP_PROG: begin
                show_status = 1'b1;
                flip6       = rd_stb;
                flip2       = rd_stb && in_sel;
            end
            ST_SUSP: begin
                show_status = in_sel;
                flip2       = rd_stb && in_sel;
            end
            ST_PROG, ST_PROT: begin
                show_status = 1'b1;
                flip6       = rd_stb;
            end
            default: show_status = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
    import fts_pkg::*;
#(
    parameter  int unsigned CLK_HZ         = 50_000_000,
    parameter  int unsigned ERASE_GUARD_US = 100,
    parameter  int unsigned PROG_GUARD_US  = 1,
    parameter  int unsigned N_SECT         = 8,
    localparam int unsigned SECT_W         = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic [7:0]        arr_data,
    input  logic              cmd_erase,
    input  logic [N_SECT-1:0] erase_sel,
    input  logic              cmd_prog,
    input  logic [SECT_W-1:0] prog_sect,
    input  logic [N_SECT-1:0] prot_map,
    input  logic              cmd_susp,
    input  logic              cmd_resume,
    input  logic              op_done,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int unsigned ERASE_WIN  = CYC_PER_US * ERASE_GUARD_US;
    localparam int unsigned PROG_WIN   = CYC_PER_US * PROG_GUARD_US;

    fts_state_e     st_q;
    logic           tim_load, tim_long, tim_zero;
    logic           tog_clr, flip6, flip2, show_status;
    logic           t6_q, t2_q;
    logic [7:0]     rd_data_q;
    logic           rd_valid_q;

    fts_ctrl #(
        .N_SECT (N_SECT),
        .SECT_W (SECT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_stb      (rd_stb),
        .rd_sect     (rd_sect),
        .cmd_erase   (cmd_erase),
        .erase_sel   (erase_sel),
        .cmd_prog    (cmd_prog),
        .prog_sect   (prog_sect),
        .prot_map    (prot_map),
        .cmd_susp    (cmd_susp),
        .cmd_resume  (cmd_resume),
        .op_done     (op_done),
        .tim_zero    (tim_zero),
        .state       (st_q),
        .tim_load    (tim_load),
        .tim_long    (tim_long),
        .tog_clr     (tog_clr),
        .flip6       (flip6),
        .flip2       (flip2),
        .show_status (show_status)
    );

    fts_timer #(
        .LONG_WIN  (ERASE_WIN),
        .SHORT_WIN (PROG_WIN)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tim_load),
        .long_sel (tim_long),
        .zero     (tim_zero)
    );

    fts_toggle u_toggle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tog_clr),
        .flip6 (flip6),
        .flip2 (flip2),
        .t6    (t6_q),
        .t2    (t2_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_stb;
            if (rd_stb) begin
                rd_data_q <= show_status ? pack_status(t6_q, t2_q) : arr_data;
            end
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/fts_checker.sv
module fts_checker
    import fts_pkg::*;
#(
    parameter int unsigned LONG_WIN = 5000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic [7:0] arr_data,
    input logic       cmd_erase,
    input logic       cmd_prog,
    input logic       cmd_susp,
    input fts_state_e st,
    input logic       t6
);
    int unsigned prot_run;

    always_ff @(posedge clk) begin
        if (!rst_n) prot_run <= 0;
        else if (st == ST_PROT) prot_run <= prot_run + 1;
        else prot_run <= 0;
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);

    p_array_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_READ) |=> (rd_data == $past(arr_data)));

    p_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (st == ST_ERASE || st == ST_PROG || st == ST_PROT || st == ST_SUSP_PROG))
        |=> (rd_data[7] == 1'b0 && rd_data[5:3] == 3'b000 && rd_data[1:0] == 2'b00));

    p_bit6_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st == ST_ERASE) |=> (t6 != $past(t6)));

    p_susp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP && !cmd_prog) |=> (t6 == $past(t6)));

    p_ignore_susp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && cmd_susp && !cmd_erase && !cmd_prog) |=> (st == ST_READ));

    p_prot_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROT) |-> (prot_run < LONG_WIN));

endmodule

bind flash_toggle_status fts_checker #(.LONG_WIN(ERASE_WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .arr_data  (arr_data),
    .cmd_erase (cmd_erase),
    .cmd_prog  (cmd_prog),
    .cmd_susp  (cmd_susp),
    .st        (st_q),
    .t6        (t6_q)
);

// File: tb/test_flash_toggle_status.sv
module test_flash_toggle_status;

    localparam int N_SECT = 8;
    localparam int SW     = 3;
    localparam int LONG   = 50 * 100;
    localparam int SHORT  = 50 * 1;

    typedef enum int {M_READ, M_ERASE, M_SUSP, M_SPROG, M_PROG, M_PROT} mst_e;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_stb = 1'b0;
    logic [SW-1:0]     rd_sect = '0;
    logic [7:0]        arr_data = '0;
    logic              cmd_erase = 1'b0;
    logic [N_SECT-1:0] erase_sel = '0;
    logic              cmd_prog = 1'b0;
    logic [SW-1:0]     prog_sect = '0;
    logic [N_SECT-1:0] prot_map = '0;
    logic              cmd_susp = 1'b0;
    logic              cmd_resume = 1'b0;
    logic              op_done = 1'b0;
    logic [7:0]        rd_data;
    logic              rd_valid;

    flash_toggle_status #(
        .CLK_HZ         (50_000_000),
        .ERASE_GUARD_US (100),
        .PROG_GUARD_US  (1),
        .N_SECT         (N_SECT)
    ) i_flash_toggle_status (
        .clk (clk), .rst_n (rst_n), .rd_stb (rd_stb), .rd_sect (rd_sect),
        .arr_data (arr_data), .cmd_erase (cmd_erase), .erase_sel (erase_sel),
        .cmd_prog (cmd_prog), .prog_sect (prog_sect), .prot_map (prot_map),
        .cmd_susp (cmd_susp), .cmd_resume (cmd_resume), .op_done (op_done),
        .rd_data (rd_data), .rd_valid (rd_valid)
    );

    always #10 clk = ~clk;

    mst_e        m_st = M_READ;
    mst_e        m_ret = M_READ;
    int          m_left = 0;
    logic        m6 = 1'b0, m2 = 1'b0;
    logic [7:0]  m_mask = '0;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;

    function automatic logic [7:0] stat_word(input logic a, input logic b);
        return {1'b0, a, 3'b000, b, 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One clock edge: model the edge from the driven inputs, then check outputs.
    task automatic edge_step(input string tag);
        logic       rd;
        logic [7:0] ex;
        logic       sel, fl6, fl2, clr;
        logic [7:0] eff;
        rd  = rd_stb;
        sel = m_mask[rd_sect];
        ex  = arr_data;
        fl6 = 1'b0; fl2 = 1'b0; clr = 1'b0;
        if (rd) begin
            case (m_st)
                M_READ:  ex = arr_data;
                M_ERASE, M_SPROG: begin ex = stat_word(m6, m2); fl6 = 1'b1; fl2 = sel; end
                M_SUSP:  begin ex = sel ? stat_word(m6, m2) : arr_data; fl2 = sel; end
                default: begin ex = stat_word(m6, m2); fl6 = 1'b1; end
            endcase
        end
        eff = erase_sel & ~prot_map;
        case (m_st)
            M_READ: begin
                if (cmd_erase && erase_sel != 0) begin
                    clr = 1'b1;
                    if (eff != 0) begin m_st = M_ERASE; m_mask = eff; end
                    else begin m_st = M_PROT; m_ret = M_READ; m_left = LONG; m_mask = 0; end
                end else if (cmd_prog) begin
                    clr = 1'b1;
                    if (prot_map[prog_sect]) begin m_st = M_PROT; m_ret = M_READ; m_left = SHORT; end
                    else m_st = M_PROG;
                end
            end
            M_ERASE: begin
                if (cmd_susp) m_st = M_SUSP;
                else if (op_done) begin m_st = M_READ; m_mask = 0; end
            end
            M_SUSP: begin
                if (cmd_prog) begin
                    clr = 1'b1;
                    if (prot_map[prog_sect]) begin m_st = M_PROT; m_ret = M_SUSP; m_left = SHORT; end
                    else m_st = M_SPROG;
                end else if (cmd_resume) m_st = M_ERASE;
            end
            M_SPROG: if (op_done) m_st = M_SUSP;
            M_PROG:  if (op_done) m_st = M_READ;
            default: begin
                m_left = m_left - 1;
                if (m_left == 0) m_st = m_ret;
            end
        endcase
        if (clr) begin m6 = 1'b0; m2 = 1'b0; end
        else begin
            if (fl6) m6 = ~m6;
            if (fl2) m2 = ~m2;
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R1 valid"}, 32'(rd_valid), 32'(rd));
        if (rd) chk(tag, 32'(rd_data), 32'(ex));
        rd_stb = 1'b0; cmd_erase = 1'b0; cmd_prog = 1'b0;
        cmd_susp = 1'b0; cmd_resume = 1'b0; op_done = 1'b0;
    endtask

    task automatic do_read(input int sect, input string tag);
        rd_stb = 1'b1; rd_sect = SW'(sect); arr_data = 8'($urandom);
        edge_step(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) edge_step("R1");
    endtask

    task automatic do_erase(input logic [7:0] sel, input logic [7:0] prot, input string tag);
        cmd_erase = 1'b1; erase_sel = sel; prot_map = prot;
        edge_step(tag);
    endtask

    task automatic do_prog(input int sect, input logic [7:0] prot, input string tag);
        cmd_prog = 1'b1; prog_sect = SW'(sect); prot_map = prot;
        edge_step(tag);
    endtask

    task automatic pulse_susp(input string tag);   cmd_susp = 1'b1;   edge_step(tag); endtask
    task automatic pulse_resume(input string tag); cmd_resume = 1'b1; edge_step(tag); endtask
    task automatic pulse_done(input string tag);   op_done = 1'b1;    edge_step(tag); endtask

    task automatic summary();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1 got=running exp=finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 reset valid", 32'(rd_valid), 0);
        chk("R1 reset data", 32'(rd_data), 0);
        // R2: array reads
        do_read(0, "R2"); do_read(5, "R2");
        // R12: illegal commands in read mode
        pulse_susp("R12"); pulse_resume("R12"); pulse_done("R12");
        do_read(3, "R12");
        // R3 R4 R13: erase sectors 1,2; read right after command
        do_erase(8'h06, 8'h00, "R13");
        do_read(1, "R13 R4"); do_read(1, "R4"); do_read(5, "R3 R4");
        do_read(2, "R4"); do_read(6, "R3");
        do_erase(8'hF0, 8'h00, "R12");
        do_read(1, "R12 R3");
        // R5: suspend
        pulse_susp("R5");
        do_read(5, "R5"); do_read(1, "R5"); do_read(2, "R5"); do_read(0, "R5");
        // R7: program in suspend
        do_prog(7, 8'h00, "R7");
        do_read(7, "R7"); do_read(3, "R7"); do_read(1, "R7");
        pulse_done("R7");
        do_read(4, "R7 R5"); do_read(2, "R7 R5");
        // R6: resume
        pulse_resume("R6");
        do_read(0, "R6"); do_read(0, "R6");
        pulse_done("R6");
        do_read(1, "R6 R2");
        // R10: partial protection
        do_erase(8'h0F, 8'h03, "R10");
        do_read(0, "R10"); do_read(2, "R10"); do_read(1, "R10"); do_read(3, "R10");
        pulse_done("R10");
        // R11: normal program
        do_prog(4, 8'h00, "R11");
        do_read(4, "R11"); do_read(0, "R11"); do_read(4, "R11");
        pulse_done("R11");
        do_read(4, "R11");
        // R9: protected program, window boundary
        do_prog(2, 8'h04, "R9");
        idle(SHORT - 1);
        do_read(2, "R9 last"); do_read(2, "R9 after");
        // R9: protected program from suspend returns to suspend
        do_erase(8'h01, 8'h00, "R9");
        pulse_susp("R9");
        do_prog(6, 8'h40, "R9");
        idle(SHORT - 1);
        do_read(6, "R9 last"); do_read(6, "R9 after"); do_read(0, "R9 susp");
        pulse_resume("R9"); pulse_done("R9");
        // R8: all-protected erase, window boundary
        do_erase(8'h30, 8'h30, "R8");
        do_read(4, "R8"); do_read(1, "R8");
        idle(LONG - 3);
        do_read(4, "R8 last"); do_read(4, "R8 after");
        // Random phase
        for (int it = 0; it < 2500; it++) begin
            int          r;
            int          u;
            logic [7:0]  pr;
            r  = int'($urandom % 16);
            u  = int'($urandom % N_SECT);
            pr = 8'($urandom);
            pr[u] = 1'b0;
            if (r <= 8) do_read(int'($urandom % N_SECT), "R3 R4 R5");
            else if (r == 9) do_erase(8'($urandom) | (8'h01 << u), pr, "R10 R12");
            else if (r == 10) do_prog(u, pr, "R7 R11");
            else if (r == 11) pulse_susp("R5 R12");
            else if (r == 12) pulse_resume("R6 R12");
            else if (r <= 14) pulse_done("R11 R12");
            idle(int'($urandom % 3));
        end
        summary();
    end

endmodule